// File: doc/BRIEF.md
# Two-Bank Physical Register Allocator with Periodic Preference Rotation

This block hands out physical register tags to a rename stage and takes them back from retirement. The physical file is treated as two equal halves. At any moment one half is preferred for new allocations and the other is only a fallback. The preference swaps after a fixed number of clock cycles, so that allocation activity, and with it heat, alternates between the halves. No register contents move when the preference swaps. Registers already live in the half that has just lost preference stay allocated and readable until retirement releases them, so that half drains by itself.

Each half keeps a bitmap of free entries. Within the selected half, the lowest free index wins. Release requests may target either half at any time. A release that names a register that is already free is reported and otherwise ignored. A per-half flag tells power control whether the currently non-preferred half still holds live registers, which shows when that half can truly be put to sleep.

Top module: `bank_reg_alloc`

## Requirements
- R1: After reset, every register is free except indices 0 to RESERVED-1 of half 0, which stay allocated. Half 0 is preferred and the rotation counter starts at zero.
- R2: A granted tag is {half bit in the MSB, entry index in the low bits}. It names the lowest-index free entry of the half it comes from. The granted entry is no longer free from the next cycle onward.
- R3: The grant comes from the preferred half whenever that half has a free entry. The other half is used only when the preferred half has none.
- R4: When `alloc_req` is high and neither half has a free entry, `alloc_valid` stays low and no entry changes state.
- R5: A release of an allocated tag makes that entry free from the next cycle onward, whichever half is preferred.
- R6: A release of an already free tag raises `free_err` in the same cycle and changes no state.
- R7: A register released in cycle N is not granted in cycle N. It can be granted from cycle N+1 onward.
- R8: `primary_bank` toggles once every SWITCH_PERIOD clock cycles, counted from the first cycle after reset.
- R9: A change of preference leaves every entry in its current free or allocated state.
- R10: `idle_bank_busy[b]` is high exactly when half b is not preferred and has at least one allocated entry.
- R11: While `alloc_req` is low, `alloc_valid` is low and no entry is allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Rename asks for one register this cycle |
| alloc_valid | output | 1 | A register is granted this cycle |
| alloc_tag | output | IDX_W+1 | Granted tag, half bit in the MSB |
| free_req | input | 1 | Retirement returns one register this cycle |
| free_tag | input | IDX_W+1 | Tag being returned |
| free_err | output | 1 | Returned tag was already free |
| primary_bank | output | 1 | Currently preferred half |
| idle_bank_busy | output | 2 | Per half: non-preferred and still holding live registers |

## Verification
The assertions assume one allocation and one release at most per cycle, with a `free_tag` that lies inside the file. They do not assume the release is legitimate: double releases are legal input and must be flagged. The stimulus draws release tags from the whole 64-entry range, including entries known to be free. It also contains a fill phase that exhausts both halves across a preference swap, so the fallback, stall and drain paths are all reached.

// File: rtl/bank_reg_alloc.sv
module bank_reg_alloc #(
  parameter int BANK_REGS     = 32,
  parameter int SWITCH_PERIOD = 10_000_000,
  parameter int RESERVED      = 0,
  localparam int IDX_W = $clog2(BANK_REGS),
  localparam int TAG_W = IDX_W + 1,
  localparam int CNT_W = $clog2(SWITCH_PERIOD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_req,
  output logic             alloc_valid,
  output logic [TAG_W-1:0] alloc_tag,
  input  logic             free_req,
  input  logic [TAG_W-1:0] free_tag,
  output logic             free_err,
  output logic             primary_bank,
  output logic [1:0]       idle_bank_busy
);
  localparam logic [BANK_REGS-1:0] RSV_MASK = BANK_REGS'((64'(1) << RESERVED) - 64'(1));

  logic [1:0][BANK_REGS-1:0] free_q;
  logic [1:0][IDX_W-1:0]     pick_idx;
  logic [1:0]                pick_hit;
  logic [CNT_W-1:0]          cnt_q;
  logic                      prim_q;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_comb begin
      pick_hit[b] = 1'b0;
      pick_idx[b] = '0;
      for (int i = BANK_REGS - 1; i >= 0; i--) begin
        if (free_q[b][i]) begin
          pick_hit[b] = 1'b1;
          pick_idx[b] = IDX_W'(i);
        end
      end
    end
    assign idle_bank_busy[b] = (prim_q != 1'(b)) && (free_q[b] != '1);
  end

  wire             sel_bank = pick_hit[prim_q] ? prim_q : ~prim_q;
  wire             rel_bank = free_tag[TAG_W-1];
  wire [IDX_W-1:0] rel_idx  = free_tag[IDX_W-1:0];

  assign alloc_valid  = alloc_req && (|pick_hit);
  assign alloc_tag    = {sel_bank, pick_idx[sel_bank]};
  assign free_err     = free_req && free_q[rel_bank][rel_idx];
  assign primary_bank = prim_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q[0] <= ~RSV_MASK;
      free_q[1] <= '1;
      cnt_q     <= '0;
      prim_q    <= 1'b0;
    end else begin
      if (alloc_valid) free_q[sel_bank][pick_idx[sel_bank]] <= 1'b0;
      if (free_req && !free_err) free_q[rel_bank][rel_idx] <= 1'b1;
      if (cnt_q == CNT_W'(SWITCH_PERIOD - 1)) begin
        cnt_q  <= '0;
        prim_q <= ~prim_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

module bank_reg_alloc_chk #(
  parameter int BANK_REGS = 32,
  parameter int CNT_W     = 24,
  localparam int IDX_W = $clog2(BANK_REGS),
  localparam int TAG_W = IDX_W + 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   alloc_req,
  input logic                   alloc_valid,
  input logic [TAG_W-1:0]       alloc_tag,
  input logic                   free_req,
  input logic [TAG_W-1:0]       free_tag,
  input logic                   free_err,
  input logic                   primary_bank,
  input logic [1:0]             idle_bank_busy,
  input logic [2*BANK_REGS-1:0] free_map,
  input logic [CNT_W-1:0]       cnt_q
);
  p_tag_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |-> free_map[alloc_tag]);

  p_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |=> !free_map[$past(alloc_tag)]);

  p_fallback_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_tag[TAG_W-1] != primary_bank)
      |-> free_map[primary_bank*BANK_REGS +: BANK_REGS] == '0);

  p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && !alloc_valid && !free_req) |=> $stable(free_map));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (free_req && !free_err) |=> free_map[$past(free_tag)]);

  p_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(primary_bank) |-> cnt_q == '0);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_bank_busy[primary_bank]);
endmodule

bind bank_reg_alloc bank_reg_alloc_chk #(.BANK_REGS(BANK_REGS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_valid(alloc_valid),
  .alloc_tag(alloc_tag), .free_req(free_req), .free_tag(free_tag), .free_err(free_err),
  .primary_bank(primary_bank), .idle_bank_busy(idle_bank_busy),
  .free_map(free_q), .cnt_q(cnt_q)
);

// File: tb/bank_reg_alloc_bench.sv
`timescale 1ns/1ps
module bank_reg_alloc_bench;
  localparam int NB = 32;
  localparam int PER = 50;
  localparam int RSV = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_req = 1'b0, free_req = 1'b0;
  logic [5:0] free_tag = '0;
  logic alloc_valid, free_err, primary_bank;
  logic [5:0] alloc_tag;
  logic [1:0] idle_bank_busy;

  int checks = 0, failures = 0;
  logic [63:0] mfree;
  logic mprim;
  int mcnt;
  logic [5:0] last_tag;

  always #4 clk = ~clk;

  bank_reg_alloc #(.BANK_REGS(NB), .SWITCH_PERIOD(PER), .RESERVED(RSV)) u_bank_reg_alloc (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_valid(alloc_valid),
    .alloc_tag(alloc_tag), .free_req(free_req), .free_tag(free_tag), .free_err(free_err),
    .primary_bank(primary_bank), .idle_bank_busy(idle_bank_busy));

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] pick_exp(input logic [63:0] fm, input logic p);
    for (int h = 0; h < 2; h++) begin
      logic b = (h == 0) ? p : ~p;
      for (int i = 0; i < NB; i++)
        if (fm[b*NB+i]) return {1'b1, b, 5'(i)};
    end
    return 7'd0;
  endfunction

  function automatic logic [1:0] busy_exp(input logic [63:0] fm, input logic p);
    logic [1:0] r;
    r[0] = (p != 1'b0) && (fm[31:0] != '1);
    r[1] = (p != 1'b1) && (fm[63:32] != '1);
    return r;
  endfunction

  task automatic step(input logic a, input logic f, input logic [5:0] t);
    logic [6:0] pk;
    logic [6:0] expv, actv;
    logic eerr;
    string lab;
    alloc_req = a; free_req = f; free_tag = t;
    #1;
    pk   = pick_exp(mfree, mprim);
    expv = a ? pk : 7'd0;
    actv = alloc_valid ? {1'b1, alloc_tag} : 7'd0;
    if (!a) lab = "R11";
    else if (!pk[6]) lab = "R4 R7";
    else if (pk[5] != mprim) lab = "R3";
    else lab = "R2";
    check(actv == expv, lab, 8'(actv), 8'(expv));
    eerr = f && mfree[t];
    check(free_err == eerr, "R5 R6", 8'(free_err), 8'(eerr));
    check(primary_bank == mprim, "R8", 8'(primary_bank), 8'(mprim));
    check(idle_bank_busy == busy_exp(mfree, mprim), "R10 R9", 8'(idle_bank_busy),
          8'(busy_exp(mfree, mprim)));
    if (alloc_valid) last_tag = alloc_tag;
    if (a && pk[6]) mfree[pk[5:0]] = 1'b0;
    if (f && !eerr) mfree[t] = 1'b1;
    if (mcnt == PER - 1) begin mcnt = 0; mprim = ~mprim; end else mcnt++;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    mfree = '1;
    mfree[RSV-1:0] = '0;
    mprim = 1'b0; mcnt = 0; last_tag = '0;
    repeat (3) @(negedge clk);
    // R1: reset state seen through the ports
    alloc_req = 1'b1; #1;
    check(alloc_valid && alloc_tag == 6'(RSV), "R1", 8'(alloc_tag), 8'(RSV));
    check(primary_bank == 1'b0 && idle_bank_busy == 2'b00, "R1",
          8'({primary_bank, idle_bank_busy}), 8'd0);
    alloc_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // fill both halves across a swap; fallback (R3) and stall (R4) paths
    for (int k = 0; k < 70; k++) step(1'b1, 1'b0, 6'd0);
    // R7: release while everything is full; no grant this cycle, grant next cycle
    step(1'b1, 1'b1, 6'd40);
    step(1'b1, 1'b0, 6'd0);
    check(last_tag == 6'd40, "R7", 8'(last_tag), 8'd40);
    // R5 R9: release from each half regardless of preference; entries kept across swaps
    step(1'b0, 1'b1, 6'd3);
    step(1'b0, 1'b1, 6'd35);
    // R6: double release of the same tag
    step(1'b0, 1'b1, 6'd35);
    for (int k = 0; k < 120; k++) step(1'b0, 1'b0, 6'd0);
    step(1'b1, 1'b0, 6'd0);

    // random: release heavy, then balanced, then allocation heavy
    for (int ph = 0; ph < 3; ph++) begin
      for (int k = 0; k < 1200; k++) begin
        int ra = (ph == 0) ? 30 : (ph == 1) ? 55 : 80;
        logic a = ($urandom % 100) < ra;
        logic f = ($urandom % 100) < 50;
        logic [5:0] t = 6'($urandom % 64);
        step(a, f, t);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule